// File: doc/BRIEF.md
# Nonvolatile Array Refresh Sequencer

The refresh sequencer is a hardware engine that walks every byte of a byte-addressable nonvolatile data array. It rewrites each location with the value it already holds, which restores charge in cells that are rarely written. Software starts a pass with a single pulse. The engine then owns the array port of the protected write controller until the pass ends. For each location it reads the stored byte and issues the two-key unlock handshake itself. It then starts the write-back and waits for the controller's write-in-progress flag to drop before it moves to the next address.

While a pass runs, the engine holds an interrupt-mask output high so that no interrupt handler can disturb the unlock sequence. Termination comes from the address counter rolling over to zero. Nothing compares the address against a limit. A progress counter reports how many locations the current pass has rewritten. An abort request ends the pass cleanly, but only at a boundary between locations.

Top module: `nvr_refresh_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `irq_mask_o`, `nv_wren_o`, `nv_rd_req_o`, `nv_key_we_o` and `nv_wr_start_o` are low, and `nv_addr_o` and `loc_count_o` are zero.
- R2: A start pulse in idle raises `irq_mask_o` on the following cycle while `nv_wren_o` is still low. `nv_wren_o` rises one cycle later, before the first read request. `nv_wren_o` is never high without `irq_mask_o`.
- R3: For each location, `nv_rd_req_o` is held until `nv_rd_ack_i`. The byte presented on `nv_rd_data_i` with the acknowledge is written back unchanged on `nv_wr_data_o` to the same address.
- R4: Every write start is immediately preceded by two key writes (`nv_key_we_o` high) on consecutive cycles carrying 0x55 and then 0xAA. The write start comes on the cycle right after the 0xAA key.
- R5: While `nv_wip_i` is high, the engine issues no read, no key write and no write start, and `nv_addr_o` holds still. The engine advances only after the flag is low.
- R6: A pass starts at address 0 and visits addresses in ascending order, each exactly once. It ends when the address rolls over to 0, with `loc_count_o` equal to the array size (2^ADDR_W).
- R7: At the end of a pass, `nv_wren_o` falls at least one cycle before `irq_mask_o` falls.
- R8: A completed pass produces a `done_o` pulse exactly one cycle wide, in the first idle cycle. In that cycle `irq_mask_o` and `nv_wren_o` are already low.
- R9: A start pulse while busy is ignored: the pass neither restarts nor repeats any location, and `loc_count_o` still ends at the array size.
- R10: An abort request while busy is held until the current location's write-back has completed, then the engine goes idle with `nv_wren_o` and `irq_mask_o` low and no `done_o` pulse. An abort in idle has no effect on the next pass. `nv_wren_o` stays high for as long as `nv_wip_i` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a refresh pass (ignored while busy) |
| abort_i | input | 1 | Stop the pass at the next location boundary |
| busy_o | output | 1 | A pass is in progress |
| done_o | output | 1 | One-cycle pulse after a completed pass |
| irq_mask_o | output | 1 | Holds interrupts off while high |
| loc_count_o | output | ADDR_W+1 | Locations rewritten in the current pass |
| nv_addr_o | output | ADDR_W | Array address to the write controller |
| nv_rd_req_o | output | 1 | Read request, held until acknowledged |
| nv_rd_ack_i | input | 1 | Read acknowledge, data valid |
| nv_rd_data_i | input | DATA_W | Read data |
| nv_wren_o | output | 1 | Write-enable level to the controller |
| nv_key_we_o | output | 1 | Strobe writing an unlock key |
| nv_key_o | output | 8 | Unlock key value |
| nv_wr_start_o | output | 1 | One-cycle write start |
| nv_wr_data_o | output | DATA_W | Write-back data |
| nv_wip_i | input | 1 | Write in progress, high from the cycle after a write start |

## Verification
On every cycle, the bound assertions check the ordering rules that hold locally. These are the key pair directly ahead of each write start, the silence while a write is in progress, the address step, the order in which write enable and the mask are released, and the width of the done pulse. Other properties need a whole pass to show. These include the value written back matching the stored byte, each address being rewritten exactly once, a start during a pass changing nothing, and an abort landing only on a location boundary. The bench shows these through a scoreboard of expected address and data pairs and a model of the protected controller.

// File: rtl/nvr_pkg.sv
package nvr_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_MASK,
    ST_READ,
    ST_KEY1,
    ST_KEY2,
    ST_FIRE,
    ST_WAIT,
    ST_STEP,
    ST_DISARM
  } nvr_state_e;

  localparam logic [7:0] UNLOCK_FIRST  = 8'h55;
  localparam logic [7:0] UNLOCK_SECOND = 8'hAA;

  function automatic logic [7:0] key_for(input nvr_state_e st);
    case (st)
      ST_KEY1: key_for = UNLOCK_FIRST;
      ST_KEY2: key_for = UNLOCK_SECOND;
      default: key_for = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/nvr_addr_ctr.sv
module nvr_addr_ctr #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W:0]   loc_cnt,
  output logic              at_last
);

  function automatic logic [ADDR_W-1:0] addr_succ(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic [ADDR_W:0] cnt_succ(input logic [ADDR_W:0] c);
    return c + 1'b1;
  endfunction

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W:0]   cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (clear) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (step) begin
      addr_q <= addr_succ(addr_q);
      cnt_q  <= cnt_succ(cnt_q);
    end
  end

  // the pass ends when the successor rolls over to zero
  assign at_last = (addr_succ(addr_q) == '0);
  assign addr    = addr_q;
  assign loc_cnt = cnt_q;

endmodule

// File: rtl/nvr_data_hold.sv
module nvr_data_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  logic [DATA_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    hold_q <= '0;
    else if (load) hold_q <= din;
  end

  assign dout = hold_q;

endmodule

// File: rtl/nvr_seq_fsm.sv
module nvr_seq_fsm
  import nvr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_req,
  input  logic       abort_req,
  input  logic       rd_ack,
  input  logic       wip,
  input  logic       at_last,
  output logic       busy,
  output logic       irq_mask,
  output logic       wren,
  output logic       done,
  output logic       ctr_clear,
  output logic       ctr_step,
  output logic       data_load,
  output logic       rd_req,
  output logic       key_we,
  output logic [7:0] key_val,
  output logic       wr_fire
);

  nvr_state_e state_q, state_d;
  logic       mask_q, wren_q, done_q, abort_pend_q, full_q;
  logic       stop_now;

  assign stop_now = abort_pend_q | abort_req;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (start_req) state_d = ST_MASK;
      ST_MASK:   state_d = ST_READ;
      ST_READ:   if (rd_ack) state_d = ST_KEY1;
      ST_KEY1:   state_d = ST_KEY2;
      ST_KEY2:   state_d = ST_FIRE;
      ST_FIRE:   state_d = ST_WAIT;
      ST_WAIT:   if (!wip) state_d = ST_STEP;
      ST_STEP:   state_d = (at_last || stop_now) ? ST_DISARM : ST_READ;
      ST_DISARM: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      mask_q       <= 1'b0;
      wren_q       <= 1'b0;
      done_q       <= 1'b0;
      abort_pend_q <= 1'b0;
      full_q       <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= 1'b0;
      if (state_q == ST_IDLE)  abort_pend_q <= 1'b0;
      else if (abort_req)      abort_pend_q <= 1'b1;
      if (state_q == ST_IDLE && start_req) mask_q <= 1'b1;
      if (state_q == ST_MASK)              wren_q <= 1'b1;
      if (state_q == ST_STEP && state_d == ST_DISARM) begin
        wren_q <= 1'b0;
        full_q <= at_last;
      end
      if (state_q == ST_DISARM) begin
        mask_q <= 1'b0;
        done_q <= full_q;
      end
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign irq_mask  = mask_q;
  assign wren      = wren_q;
  assign done      = done_q;
  assign ctr_clear = (state_q == ST_IDLE) && start_req;
  assign ctr_step  = (state_q == ST_STEP);
  assign data_load = (state_q == ST_READ) && rd_ack;
  assign rd_req    = (state_q == ST_READ);
  assign key_we    = (state_q == ST_KEY1) || (state_q == ST_KEY2);
  assign key_val   = key_for(state_q);
  assign wr_fire   = (state_q == ST_FIRE);

endmodule

// File: rtl/nvr_refresh_seq.sv
module nvr_refresh_seq #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              abort_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              irq_mask_o,
  output logic [ADDR_W:0]   loc_count_o,
  output logic [ADDR_W-1:0] nv_addr_o,
  output logic              nv_rd_req_o,
  input  logic              nv_rd_ack_i,
  input  logic [DATA_W-1:0] nv_rd_data_i,
  output logic              nv_wren_o,
  output logic              nv_key_we_o,
  output logic [7:0]        nv_key_o,
  output logic              nv_wr_start_o,
  output logic [DATA_W-1:0] nv_wr_data_o,
  input  logic              nv_wip_i
);

  // named internal events, visible to the bound checker
  logic ctr_clear_ev;
  logic step_ev;
  logic load_ev;
  logic last_loc;

  nvr_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_i),
    .abort_req (abort_i),
    .rd_ack    (nv_rd_ack_i),
    .wip       (nv_wip_i),
    .at_last   (last_loc),
    .busy      (busy_o),
    .irq_mask  (irq_mask_o),
    .wren      (nv_wren_o),
    .done      (done_o),
    .ctr_clear (ctr_clear_ev),
    .ctr_step  (step_ev),
    .data_load (load_ev),
    .rd_req    (nv_rd_req_o),
    .key_we    (nv_key_we_o),
    .key_val   (nv_key_o),
    .wr_fire   (nv_wr_start_o)
  );

  nvr_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (ctr_clear_ev),
    .step    (step_ev),
    .addr    (nv_addr_o),
    .loc_cnt (loc_count_o),
    .at_last (last_loc)
  );

  nvr_data_hold #(.DATA_W(DATA_W)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load_ev),
    .din   (nv_rd_data_i),
    .dout  (nv_wr_data_o)
  );

endmodule

// File: rtl/nvr_refresh_chk.sv
module nvr_refresh_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              irq_mask,
  input logic              wren,
  input logic              done,
  input logic              rd_req,
  input logic              key_we,
  input logic [7:0]        key,
  input logic              wr_start,
  input logic              wip,
  input logic [ADDR_W-1:0] addr,
  input logic              step_ev
);

  // R2
  wren_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wren |-> irq_mask && busy);

  // R4
  key_then_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |-> $past(key_we && key == 8'hAA));

  // R4
  key_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_we && key == 8'hAA) |-> $past(key_we && key == 8'h55));

  // R5
  quiet_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wip |-> !rd_req && !key_we && !wr_start);

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wip && $past(wip)) |-> $stable(addr));

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_ev |=> addr == ADDR_W'($past(addr) + 1'b1));

  // R7
  disarm_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_mask) |-> !$past(wren));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !irq_mask && !wren && !busy);

  // R10
  write_kept_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wip |-> wren && busy);

endmodule

bind nvr_refresh_seq nvr_refresh_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy_o),
  .irq_mask (irq_mask_o),
  .wren     (nv_wren_o),
  .done     (done_o),
  .rd_req   (nv_rd_req_o),
  .key_we   (nv_key_we_o),
  .key      (nv_key_o),
  .wr_start (nv_wr_start_o),
  .wip      (nv_wip_i),
  .addr     (nv_addr_o),
  .step_ev  (step_ev)
);

// File: tb/sim_nvr_refresh_seq.sv
module sim_nvr_refresh_seq;
  localparam int AW   = 4;
  localparam int DW   = 8;
  localparam int NLOC = 1 << AW;
  localparam int WLAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic abort_i = 1'b0;
  logic busy_o, done_o, irq_mask_o;
  logic [AW:0] loc_count_o;
  logic [AW-1:0] nv_addr_o;
  logic nv_rd_req_o, nv_wren_o, nv_key_we_o, nv_wr_start_o;
  logic [7:0] nv_key_o;
  logic [DW-1:0] nv_wr_data_o;
  logic nv_rd_ack_i = 1'b0;
  logic [DW-1:0] nv_rd_data_i = '0;
  logic nv_wip_i;

  always #10 clk = ~clk;

  nvr_refresh_seq #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
    .busy_o(busy_o), .done_o(done_o), .irq_mask_o(irq_mask_o),
    .loc_count_o(loc_count_o), .nv_addr_o(nv_addr_o),
    .nv_rd_req_o(nv_rd_req_o), .nv_rd_ack_i(nv_rd_ack_i),
    .nv_rd_data_i(nv_rd_data_i), .nv_wren_o(nv_wren_o),
    .nv_key_we_o(nv_key_we_o), .nv_key_o(nv_key_o),
    .nv_wr_start_o(nv_wr_start_o), .nv_wr_data_o(nv_wr_data_o),
    .nv_wip_i(nv_wip_i)
  );

  int checks = 0;
  int fails  = 0;
  int done_seen = 0;
  int writes_seen = 0;
  int wcount [NLOC];
  logic [DW-1:0] mem [NLOC];
  logic [DW-1:0] golden [NLOC];
  logic [AW+DW-1:0] expq [$];
  int key_seq = 0;
  int wip_cnt = 0;
  logic prev_mask = 1'b0, prev_wren = 1'b0, prev_done = 1'b0;

  assign nv_wip_i = (wip_cnt != 0);

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // protected write controller model with the array behind it
  always @(posedge clk) begin
    if (!rst_n) begin
      nv_rd_ack_i <= 1'b0;
      wip_cnt <= 0;
      key_seq <= 0;
    end else begin
      nv_rd_ack_i  <= nv_rd_req_o && !nv_rd_ack_i;
      nv_rd_data_i <= mem[nv_addr_o];
      if (nv_wr_start_o) begin
        wip_cnt <= WLAT;
        if (key_seq == 2 && nv_wren_o) mem[nv_addr_o] <= nv_wr_data_o;
      end else if (wip_cnt != 0) begin
        wip_cnt <= wip_cnt - 1;
      end
      if (nv_key_we_o && nv_key_o == 8'h55) key_seq <= 1;
      else if (nv_key_we_o && nv_key_o == 8'hAA && key_seq == 1) key_seq <= 2;
      else key_seq <= 0;
    end
  end

  // monitor: pops the scoreboard on each write start
  always @(negedge clk) begin
    if (rst_n) begin
      if (nv_wr_start_o) begin
        writes_seen++;
        wcount[nv_addr_o]++;
        // R4 unlock keys 0x55 then 0xAA directly before the write start
        check(key_seq == 2, "R4", "unlock state at write start", key_seq, 2);
        // R5 no write start while a write is in progress
        check(!nv_wip_i, "R5", "wip at write start", int'(nv_wip_i), 0);
        // R2 write enable and mask held at write start
        check(nv_wren_o && irq_mask_o, "R2", "wren&mask at write",
              int'({nv_wren_o, irq_mask_o}), 3);
        if (expq.size() == 0) begin
          check(1'b0, "R9", "unexpected extra write at address", int'(nv_addr_o), -1);
        end else begin
          logic [AW+DW-1:0] e;
          e = expq.pop_front();
          // R6 ascending address order
          check(nv_addr_o == e[AW+DW-1:DW], "R6", "write address",
                int'(nv_addr_o), int'(e[AW+DW-1:DW]));
          // R3 byte written back unchanged
          check(nv_wr_data_o == e[DW-1:0], "R3", "write-back data",
                int'(nv_wr_data_o), int'(e[DW-1:0]));
        end
      end
      if (prev_mask && !irq_mask_o)
        // R7 write enable released before the mask
        check(!prev_wren, "R7", "wren in cycle before unmask", int'(prev_wren), 0);
      if (done_o) begin
        done_seen++;
        // R8 single-cycle pulse
        check(!prev_done, "R8", "done high two cycles", 1, 0);
      end
      prev_mask = irq_mask_o;
      prev_wren = nv_wren_o;
      prev_done = done_o;
    end
  end

  task automatic fill(input int seed);
    for (int i = 0; i < NLOC; i++) begin
      mem[i] = DW'(i * 37 + seed);
      golden[i] = mem[i];
      wcount[i] = 0;
    end
    expq.delete();
    for (int i = 0; i < NLOC; i++) expq.push_back({AW'(i), golden[i]});
    writes_seen = 0;
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
  endtask

  task automatic check_full_pass(input string tag, input int done_before);
    int once_ok;
    int mem_ok;
    once_ok = 1;
    mem_ok = 1;
    for (int i = 0; i < NLOC; i++) begin
      if (wcount[i] != 1) once_ok = 0;
      if (mem[i] != golden[i]) mem_ok = 0;
    end
    // R6 every address exactly once, count equals array size
    check(int'(loc_count_o) == NLOC, "R6", {tag, " loc count"}, int'(loc_count_o), NLOC);
    check(once_ok == 1, "R6", {tag, " each address once"}, once_ok, 1);
    check(expq.size() == 0, "R6", {tag, " items left"}, expq.size(), 0);
    check(mem_ok == 1, "R3", {tag, " array unchanged"}, mem_ok, 1);
    // R8 one done pulse for the pass
    check(done_seen == done_before + 1, "R8", {tag, " done pulses"},
          done_seen - done_before, 1);
    check(!irq_mask_o && !nv_wren_o, "R7", {tag, " mask/wren after pass"},
          int'({irq_mask_o, nv_wren_o}), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : main
    int d0;
    fill(0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy_o && !done_o && !irq_mask_o && !nv_wren_o, "R1", "status after reset",
          int'({busy_o, done_o, irq_mask_o, nv_wren_o}), 0);
    check(!nv_rd_req_o && !nv_key_we_o && !nv_wr_start_o, "R1", "requests after reset",
          int'({nv_rd_req_o, nv_key_we_o, nv_wr_start_o}), 0);
    check(nv_addr_o == 0 && loc_count_o == 0, "R1", "addr/count after reset",
          int'(nv_addr_o) + int'(loc_count_o), 0);

    // pass 1, with a start pulse while busy (R9)
    fill(5);
    d0 = done_seen;
    pulse_start();
    // R2 mask first, write enable one cycle later
    check(irq_mask_o && !nv_wren_o && busy_o, "R2", "cycle after start",
          int'({irq_mask_o, nv_wren_o, busy_o}), 5);
    check(!nv_rd_req_o, "R2", "no read before wren", int'(nv_rd_req_o), 0);
    @(negedge clk);
    check(nv_wren_o && nv_rd_req_o, "R2", "wren then read",
          int'({nv_wren_o, nv_rd_req_o}), 3);
    while (loc_count_o < 3) @(negedge clk);
    pulse_start();
    wait_idle();
    @(negedge clk);
    check_full_pass("pass1 (R9 restart ignored)", d0);
    repeat (20) @(negedge clk);
    check(writes_seen == NLOC && !busy_o, "R9", "no activity after pass",
          writes_seen, NLOC);

    // pass 2, different data
    fill(91);
    d0 = done_seen;
    pulse_start();
    check(loc_count_o == 0, "R6", "count cleared at start", int'(loc_count_o), 0);
    wait_idle();
    @(negedge clk);
    check_full_pass("pass2", d0);

    // abort in the middle of a write (R10)
    fill(200);
    d0 = done_seen;
    pulse_start();
    while (!(loc_count_o == 5 && nv_wip_i)) @(negedge clk);
    abort_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0;
    check(nv_wren_o && busy_o, "R10", "write not cut by abort",
          int'({nv_wren_o, busy_o}), 3);
    wait_idle();
    @(negedge clk);
    check(loc_count_o == 6, "R10", "locations done at abort", int'(loc_count_o), 6);
    check(writes_seen == 6, "R10", "writes at abort", writes_seen, 6);
    check(!irq_mask_o && !nv_wren_o, "R10", "mask/wren after abort",
          int'({irq_mask_o, nv_wren_o}), 0);
    check(done_seen == d0, "R10", "no done on abort", done_seen - d0, 0);
    check(mem[5] == golden[5], "R10", "interrupted location intact",
          int'(mem[5]), int'(golden[5]));

    // abort while idle has no effect on next pass
    abort_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0;
    fill(33);
    d0 = done_seen;
    pulse_start();
    wait_idle();
    @(negedge clk);
    check_full_pass("pass after idle abort (R10)", d0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule